// File: doc/BRIEF.md
# Stereo Serial Audio Frame Interface

This block carries 16-bit stereo samples between a register interface and a serial audio link. On the link it drives a bit clock, a frame clock and a serial data line, and it samples a serial data input. Each frame is 128 bit periods long and carries exactly one stereo sample. The left word occupies the first 16 slots after the frame clock falls, and the right word occupies the first 16 slots after it rises. Every other slot is driven as zero. Bit timing comes either from an internal divider or from an external bit clock that is synchronised into the system clock domain.

Each direction has its own left and right FIFO: transmit FIFOs hold 8 samples and receive FIFOs hold 12. Software can preload the transmit side before it starts the link. Transfers for a channel begin only once the global enable is set and that channel's FIFO enable bit is set. Two sticky flags record a starved transmit FIFO and a receive FIFO that was full when a sample arrived. Both flags come up set out of reset and are cleared by writing 1. Two request outputs tell a service routine when the transmit side needs refilling or the receive side needs draining.

Register map (word address on `reg_addr_i`):
- 0: control, bit 0 = link enable.
- 1: status, bit 0 = underflow, bit 1 = overflow.
- 2: left data. A write pushes bits [15:0] into the left transmit FIFO. A read returns the left receive FIFO head in [15:0] and pops it.
- 3: right data, with the same behaviour for the right channel.
- 4: FIFO enables, bit 0 = transmit left, bit 1 = transmit right, bit 2 = receive left, bit 3 = receive right.

Top module: `stereo_frame_if`

## Requirements
- R1: After reset the link is idle: `lrck_o` is 1, `sdout_o` and `sclk_o` are 0, both request outputs are 0, and the status register (address 1) reads 3 (bit 0 underflow and bit 1 overflow both set).
- R2: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a hardware set event and a clearing write fall on the same clock edge, the bit ends up set.
- R3: Each transmit FIFO holds 8 samples. Software can fill it while the link is disabled, and writes to a full transmit FIFO are dropped.
- R4: A frame is 128 bit periods. `lrck_o` is low for the first 64 and high for the last 64. The left word is sent MSB first in slots 0 to 15, the right word MSB first in slots 64 to 79, and every other slot carries 0.
- R5: While control bit 0 is clear, no bit clock or data is produced. While a channel's FIFO enable bit is clear, that channel sends zeros, does not pop its transmit FIFO, does not push its receive FIFO and raises no flag.
- R6: If an enabled transmit FIFO is empty when a frame starts, that channel's word for the frame is zero and status bit 0 is set.
- R7: `sdin_i` is sampled at the end of each bit period. Bits in slots 0 to 15 form the left word and bits in slots 64 to 79 form the right word, MSB first. Each word is pushed into its enabled receive FIFO and read back in arrival order. Inputs in other slots are ignored.
- R8: Each receive FIFO holds 12 samples. A word that arrives while its FIFO is full is discarded and status bit 1 is set.
- R9: `tx_req_o` is high when the link is enabled and any enabled transmit FIFO holds 4 or fewer samples.
- R10: `rx_req_o` is high when any enabled receive FIFO holds 6 or more samples.
- R11: With `ext_sel_i` low, `sclk_o` has a period of `CLK_DIV` system clocks. It is low in the first half and high in the second. Frame clock and data change as `sclk_o` falls.
- R12: With `ext_sel_i` high, each synchronised rising edge of `sclk_i` advances exactly one bit period. With no edges the frame stalls, and `sclk_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_sel_i | input | 1 | 1 selects the external bit clock |
| sclk_i | input | 1 | External bit clock |
| sdin_i | input | 1 | Serial receive data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on data addresses) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| sclk_o | output | 1 | Internal bit clock output |
| lrck_o | output | 1 | Frame clock, low for the left half |
| sdout_o | output | 1 | Serial transmit data |
| tx_req_o | output | 1 | Transmit service request |
| rx_req_o | output | 1 | Receive service request |

## Verification
The underflow event at a frame boundary and a software write-1-to-clear of the status register can land on the same clock edge. The bench tracks bit slots from `sclk_o` and `lrck_o`. During the last bit of the frame before the transmit FIFOs run dry, it places the clearing write exactly on the edge that loads the next frame. A correct design must then read the underflow bit back as 1. The other concurrency in this block is a receive FIFO pop and a push in the same cycle; it is covered by counting every receive word back in arrival order.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LEFT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RIGHT = 3'd3;
  localparam logic [ADDR_W-1:0] A_FEN   = 3'd4;

  localparam int ST_UFL = 0;
  localparam int ST_OFL = 1;
  // FIFO enable bit for channel c: tx at c, rx at NCH + c
  localparam int FEN_W  = 2 * NCH;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R3
  AST_FULL_DROPS_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(count_o)); // R8
endmodule

// File: rtl/sfi_bitclk.sv
module sfi_bitclk #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ext_sel_i,
  input  logic sclk_i,
  output logic tick_o,
  output logic sclk_o
);
  localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [DW-1:0] div_q;
  logic [2:0]    sync_q;
  logic          tick_int, tick_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sclk_i};
      if (!run_i || ext_sel_i)             div_q <= '0;
      else if (div_q == DW'(CLK_DIV - 1))  div_q <= '0;
      else                                 div_q <= div_q + 1'b1;
    end
  end

  assign tick_int = (div_q == DW'(CLK_DIV - 1));
  assign tick_ext = sync_q[1] && !sync_q[2];
  assign tick_o   = run_i && (ext_sel_i ? tick_ext : tick_int);
  assign sclk_o   = run_i && !ext_sel_i && (div_q >= DW'(HALF));

  generate
    if (CLK_DIV > 1) begin : g_spaced
      AST_INT_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !ext_sel_i) |=> !(tick_o && !ext_sel_i)); // R11
    end
  endgenerate
  AST_EXT_TICK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ext_sel_i) |-> $past(sclk_i, 2)); // R12
endmodule

// File: rtl/sfi_frame.sv
module sfi_frame #(
  parameter int SW        = 16,
  parameter int FRAME_LEN = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [SW-1:0] tx_l_i,
  input  logic [SW-1:0] tx_r_i,
  input  logic          sdin_i,
  output logic          load_o,
  output logic          rx_l_vld_o,
  output logic          rx_r_vld_o,
  output logic [SW-1:0] rx_l_data_o,
  output logic [SW-1:0] rx_r_data_o,
  output logic          lrck_o,
  output logic          sdout_o
);
  localparam int CW   = $clog2(FRAME_LEN);
  localparam int HALF = FRAME_LEN / 2;
  localparam int BW   = $clog2(SW);

  logic [CW-1:0] cnt_q, off;
  logic [SW-1:0] l_q, r_q, shl_q, shr_q;
  logic          last, in_left, in_right;
  logic [BW-1:0] idx;

  assign last     = (cnt_q == CW'(FRAME_LEN - 1));
  assign in_left  = (cnt_q < CW'(SW));
  assign in_right = (cnt_q >= CW'(HALF)) && (cnt_q < CW'(HALF + SW));
  assign off      = in_right ? cnt_q - CW'(HALF) : cnt_q;
  assign idx      = BW'(SW - 1) - off[BW-1:0];
  assign lrck_o   = (cnt_q >= CW'(HALF));
  assign sdout_o  = in_left ? l_q[idx] : (in_right ? r_q[idx] : 1'b0);

  assign load_o      = tick_i && last;
  assign rx_l_vld_o  = tick_i && (cnt_q == CW'(SW - 1));
  assign rx_r_vld_o  = tick_i && (cnt_q == CW'(HALF + SW - 1));
  assign rx_l_data_o = {shl_q[SW-2:0], sdin_i};
  assign rx_r_data_o = {shr_q[SW-2:0], sdin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(FRAME_LEN - 1);
      l_q   <= '0;
      r_q   <= '0;
      shl_q <= '0;
      shr_q <= '0;
    end else if (!run_i) begin
      cnt_q <= CW'(FRAME_LEN - 1);
      l_q   <= '0;
      r_q   <= '0;
    end else if (tick_i) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (last) begin
        l_q <= tx_l_i;
        r_q <= tx_r_i;
      end
      if (in_left)  shl_q <= {shl_q[SW-2:0], sdin_i};
      if (in_right) shr_q <= {shr_q[SW-2:0], sdin_i};
    end
  end

  AST_LINK_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> ($stable(lrck_o) && $stable(sdout_o))); // R4
  AST_LOAD_OPENS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && run_i) |=> !lrck_o); // R4
endmodule

// File: rtl/stereo_frame_if.sv
module stereo_frame_if
  import sfi_pkg::*;
#(
  parameter int SW        = 16,
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 12,
  parameter int FRAME_LEN = 128,
  parameter int CLK_DIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_sel_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdout_o,
  output logic              tx_req_o,
  output logic              rx_req_o
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  logic             ctrl_en_q;
  logic [FEN_W-1:0] fen_q;
  logic [1:0]       flag_q, w1c, flag_set;

  logic             tick, load, ufl_evt, ofl_evt;
  logic [NCH-1:0]   rx_vld;
  logic [SW-1:0]    rx_word [NCH];
  logic [SW-1:0]    tx_head [NCH];
  logic [SW-1:0]    tx_lane [NCH];
  logic [SW-1:0]    rx_head [NCH];
  logic [TCW-1:0]   tx_cnt  [NCH];
  logic [RCW-1:0]   rx_cnt  [NCH];
  logic [NCH-1:0]   tx_empty, tx_full, rx_empty, rx_full;
  logic [NCH-1:0]   tx_low, rx_high, rx_push;

  sfi_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
    .clk_i, .rst_ni, .run_i(ctrl_en_q), .ext_sel_i, .sclk_i,
    .tick_o(tick), .sclk_o
  );

  sfi_frame #(.SW(SW), .FRAME_LEN(FRAME_LEN)) u_frame (
    .clk_i, .rst_ni, .run_i(ctrl_en_q), .tick_i(tick),
    .tx_l_i(tx_lane[0]), .tx_r_i(tx_lane[1]), .sdin_i,
    .load_o(load), .rx_l_vld_o(rx_vld[0]), .rx_r_vld_o(rx_vld[1]),
    .rx_l_data_o(rx_word[0]), .rx_r_data_o(rx_word[1]),
    .lrck_o, .sdout_o
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] DA = (c == 0) ? A_LEFT : A_RIGHT;
      logic tx_push, tx_pop, rx_pop;

      assign tx_push    = reg_we_i && (reg_addr_i == DA);
      assign tx_pop     = load && fen_q[c] && !tx_empty[c];
      assign tx_lane[c] = (fen_q[c] && !tx_empty[c]) ? tx_head[c] : '0;
      assign rx_push[c] = rx_vld[c] && fen_q[NCH+c];
      assign rx_pop     = reg_re_i && (reg_addr_i == DA);
      assign tx_low[c]  = fen_q[c] && (tx_cnt[c] <= TCW'(TX_DEPTH / 2));
      assign rx_high[c] = fen_q[NCH+c] && (rx_cnt[c] >= RCW'(RX_DEPTH / 2));

      sfi_fifo #(.DW(SW), .DEPTH(TX_DEPTH)) u_txq (
        .clk_i, .rst_ni, .push_i(tx_push), .wdata_i(reg_wdata_i[SW-1:0]),
        .pop_i(tx_pop), .rdata_o(tx_head[c]), .count_o(tx_cnt[c]),
        .empty_o(tx_empty[c]), .full_o(tx_full[c])
      );

      sfi_fifo #(.DW(SW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk_i, .rst_ni, .push_i(rx_push[c]), .wdata_i(rx_word[c]),
        .pop_i(rx_pop), .rdata_o(rx_head[c]), .count_o(rx_cnt[c]),
        .empty_o(rx_empty[c]), .full_o(rx_full[c])
      );
    end
  endgenerate

  assign ufl_evt  = load && |(fen_q[NCH-1:0] & tx_empty);
  assign ofl_evt  = |(rx_push & rx_full);
  assign flag_set = {ofl_evt, ufl_evt};
  assign w1c      = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i[1:0] : 2'b00;
  assign tx_req_o = ctrl_en_q && |tx_low;
  assign rx_req_o = |rx_high;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      fen_q     <= '0;
      flag_q    <= 2'b11;
    end else begin
      if (reg_we_i && reg_addr_i == A_CTRL) ctrl_en_q <= reg_wdata_i[0];
      if (reg_we_i && reg_addr_i == A_FEN)  fen_q     <= reg_wdata_i[FEN_W-1:0];
      // set wins over a same-cycle clear
      flag_q <= (flag_q & ~w1c) | flag_set;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o[0]       = ctrl_en_q;
      A_STAT:  reg_rdata_o[1:0]     = flag_q;
      A_LEFT:  reg_rdata_o[SW-1:0]  = rx_empty[0] ? '0 : rx_head[0];
      A_RIGHT: reg_rdata_o[SW-1:0]  = rx_empty[1] ? '0 : rx_head[1];
      A_FEN:   reg_rdata_o[FEN_W-1:0] = fen_q;
      default: reg_rdata_o = '0;
    endcase
  end

  AST_UFL_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ufl_evt |=> flag_q[ST_UFL]); // R2
  AST_OFL_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofl_evt |=> flag_q[ST_OFL]); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_q && $past(!ctrl_en_q)) |-> (!sdout_o && !sclk_o && lrck_o)); // R5
  AST_TX_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (ctrl_en_q && |fen_q[NCH-1:0])); // R9
endmodule

// File: tb/sim_stereo_frame_if.sv
module sim_stereo_frame_if;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_sel_i = 1'b0, sclk_i = 1'b0, sdin_i = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        sclk_o, lrck_o, sdout_o, tx_req_o, rx_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  stereo_frame_if u0 (
    .clk_i(clk), .rst_ni, .ext_sel_i, .sclk_i, .sdin_i,
    .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .sclk_o, .lrck_o, .sdout_o, .tx_req_o, .rx_req_o
  );

  always #10 clk = ~clk;

  logic [15:0] prim_l [8], prim_r [8];
  logic [15:0] rxl [16], rxr [16], outl [16], outr [16];
  int          pad_err = 0;
  int          frame_idx = -1, slot = 0;
  logic        prev_lr = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_re_i = 1'b0;
  endtask

  task automatic pulse_ext();
    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_tx(input int f, input bit right);
    if (f >= 1 && f <= 8) return right ? prim_r[f-1] : prim_l[f-1];
    return 16'h0; // frame 0: channels off (R5); frames 9+: underflow (R6)
  endfunction

  // slot tracker: samples mid-bit on sclk_o rise, drives sdin for the same slot
  always @(posedge sclk_o) begin
    #1;
    if (prev_lr && !lrck_o) begin
      frame_idx++;
      slot = 0;
    end else begin
      slot++;
    end
    prev_lr = lrck_o;
    if (frame_idx >= 0 && frame_idx < 16) begin
      if (slot < 16) begin
        outl[frame_idx][15-slot] = sdout_o;
        sdin_i = rxl[frame_idx][15-slot];
      end else if (slot >= 64 && slot < 80) begin
        outr[frame_idx][79-slot] = sdout_o;
        sdin_i = rxr[frame_idx][79-slot];
      end else begin
        if (sdout_o) pad_err++;
        sdin_i = 1'($urandom);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    realtime t0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      prim_l[i] = 16'($urandom);
      prim_r[i] = 16'($urandom);
    end
    prim_l[0] = 16'h8001; prim_r[0] = 16'hFFFF; // edge patterns
    for (int i = 0; i < 16; i++) begin
      rxl[i] = 16'($urandom); rxr[i] = 16'($urandom);
      outl[i] = '0; outr[i] = '0;
    end
    rxl[1] = 16'h0001; rxr[1] = 16'h8000;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(lrck_o == 1'b1 && sdout_o == 1'b0 && sclk_o == 1'b0, "R1 idle pins",
        {lrck_o, sdout_o, sclk_o}, 3'b100);
    chk(tx_req_o == 1'b0 && rx_req_o == 1'b0, "R1 requests", {tx_req_o, rx_req_o}, 0);
    rd(3'd1, d);
    chk(d == 32'd3, "R1 status after reset", d, 3);
    // R2 clear one bit at a time
    wr(3'd1, 32'd1);
    rd(3'd1, d);
    chk(d == 32'd2, "R2 clear underflow only", d, 2);
    wr(3'd1, 32'd2);
    rd(3'd1, d);
    chk(d == 32'd0, "R2 clear overflow", d, 0);
    // R3 preload, ninth write dropped
    for (int i = 0; i < 8; i++) begin
      wr(3'd2, {16'h0, prim_l[i]});
      wr(3'd3, {16'h0, prim_r[i]});
    end
    wr(3'd2, 32'h0000_DEAD);
    wr(3'd3, 32'h0000_BEEF);
    chk(tx_req_o == 1'b0, "R9 no request while link off", tx_req_o, 0);
    wr(3'd0, 32'd1);
    chk(tx_req_o == 1'b0, "R9 no request with FIFOs disabled", tx_req_o, 0);
    // R11 bit clock period
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o);
    chk(($realtime - t0) == 80.0, "R11 sclk period", int'($realtime - t0), 80);
    @(negedge sclk_o); #1;
    chk(lrck_o == 1'b0 && sclk_o == 1'b0, "R11 frame opens on sclk fall", lrck_o, 0);

    wait (frame_idx == 0 && slot == 100);
    rd(3'd1, d);
    chk(d == 32'd0, "R5 no flag with FIFOs disabled", d, 0);
    wr(3'd4, 32'hF);

    wait (frame_idx == 2 && slot == 50);
    chk(tx_req_o == 1'b0, "R9 six queued, no request", tx_req_o, 0);
    wait (frame_idx == 5 && slot == 50);
    chk(tx_req_o == 1'b1, "R9 three queued, request", tx_req_o, 1);
    wait (frame_idx == 5 && slot == 100);
    chk(rx_req_o == 1'b0, "R10 five received, no request", rx_req_o, 0);
    wait (frame_idx == 6 && slot == 100);
    chk(rx_req_o == 1'b1, "R10 six received, request", rx_req_o, 1);
    wait (frame_idx == 8 && slot == 50);
    rd(3'd1, d);
    chk(d == 32'd0, "R6 no underflow while data queued", d, 0);

    // R2 collision: clearing write on the edge that loads the starved frame
    wait (frame_idx == 8 && slot == 127);
    @(negedge clk);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 32'd1;
    @(negedge clk);
    reg_we_i = 1'b0;
    rd(3'd1, d);
    chk(d[0] == 1'b1, "R2 set wins over same-edge clear", d[0], 1);
    chk(d[0] == 1'b1, "R6 underflow flag", d[0], 1);

    wait (frame_idx == 12 && slot == 100);
    rd(3'd1, d);
    chk(d[1] == 1'b0, "R8 twelve words fit", d[1], 0);
    wait (frame_idx == 13 && slot == 100);
    rd(3'd1, d);
    chk(d[1] == 1'b1, "R8 thirteenth word overflows", d[1], 1);
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(lrck_o == 1'b1 && sdout_o == 1'b0 && sclk_o == 1'b0, "R5 link off is quiet",
        {lrck_o, sdout_o, sclk_o}, 3'b100);
    chk(tx_req_o == 1'b0, "R9 request drops with link off", tx_req_o, 0);

    for (int f = 0; f < 14; f++) begin
      chk(outl[f] == exp_tx(f, 1'b0), (f == 0) ? "R5 left frame" : (f > 8) ? "R6 left frame" : "R4 left frame",
          outl[f], exp_tx(f, 1'b0));
      chk(outr[f] == exp_tx(f, 1'b1), (f == 0) ? "R5 right frame" : (f > 8) ? "R6 right frame" : "R4 right frame",
          outr[f], exp_tx(f, 1'b1));
    end
    chk(pad_err == 0, "R4 padding slots zero", pad_err, 0);

    chk(rx_req_o == 1'b1, "R10 full FIFO requests", rx_req_o, 1);
    for (int i = 0; i < 12; i++) begin
      rd(3'd2, d);
      chk(d == {16'h0, rxl[i+1]}, "R7 left receive order", d, rxl[i+1]);
      rd(3'd3, d);
      chk(d == {16'h0, rxr[i+1]}, "R7 right receive order", d, rxr[i+1]);
    end
    rd(3'd2, d);
    chk(d == 32'd0, "R8 overflowed word discarded", d, 0);
    chk(rx_req_o == 1'b0, "R10 drained, no request", rx_req_o, 0);

    // R12 external bit clock
    rst_ni = 1'b0;
    ext_sel_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    wr(3'd0, 32'd1);
    repeat (20) @(negedge clk);
    chk(lrck_o == 1'b1 && sclk_o == 1'b0, "R12 stalls without edges", {lrck_o, sclk_o}, 2);
    pulse_ext();
    chk(lrck_o == 1'b0, "R12 first edge opens frame", lrck_o, 0);
    repeat (40) @(negedge clk);
    chk(lrck_o == 1'b0, "R12 holds between edges", lrck_o, 0);
    for (int i = 0; i < 63; i++) pulse_ext();
    chk(lrck_o == 1'b0, "R12 still left half at slot 63", lrck_o, 0);
    pulse_ext();
    chk(lrck_o == 1'b1 && sclk_o == 1'b0, "R12 right half at slot 64", {lrck_o, sclk_o}, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule